// File: doc/BRIEF.md
# Virtual Interrupt Flag Control Unit

This unit keeps the interrupt-related bits of a processor flags word: the real interrupt enable (IF), the virtual interrupt enable (VIF), the virtual-interrupt-pending bit (VIP) and the two-bit I/O privilege level (IOPL). It updates them when a flag-affecting instruction retires. The five instructions it handles are clear-interrupt, set-interrupt, push-flags, pop-flags and interrupt-return.

For each retired instruction the unit looks at four things: the operating mode (real, protected or virtual-8086), the current privilege level, the mode-extension controls and the stored IOPL. From these it decides whether the write goes to IF, is redirected to VIF, or is refused with a general-protection fault (error code zero).

Instruction decode, the stack access and fault delivery are handled elsewhere. The retire stage presents one strobe per instruction, together with the popped image for pops. It takes the image to push from `push_img_o`.

Top module: `vif_ctrl`

## Requirements
- R1: After reset IF, VIF and VIP are 0, IOPL is 0 and `gp_fault_o` is low.
- R2: In real mode (`pe_i`=0), clear-interrupt (op 0) writes IF=0 and set-interrupt (op 1) writes IF=1, whatever IOPL is. No fault is raised and VIF is unchanged.
- R3: `push_img_o` has bit 1 set, bit 9 = IF (or VIF on the virtual path), bits 13:12 = IOPL, bit 17 = `vm_i`, bit 19 = VIF, bit 20 = VIP, and all other bits 0.
- R4: In real mode, pop-flags (op 3) and interrupt-return (op 4) load IF from image bit 9 and IOPL from image bits 13:12. VIF and VIP do not change.
- R5: In protected mode (`pe_i`=1, `vm_i`=0) at privilege 0, a pop loads IF, IOPL, VIF (image bit 19) and VIP (image bit 20).
- R6: In protected mode with privilege no greater than IOPL, clear- and set-interrupt act directly on IF.
- R7: In protected mode with privilege above IOPL, clear- and set-interrupt act on VIF when `pvi_i`=1 and privilege is 3; otherwise they fault. A set-interrupt on this virtual path faults when VIP=1. Pops at this privilege change nothing and do not fault.
- R8: In virtual-8086 mode (`pe_i`=`vm_i`=1) with IOPL=3, the five instructions act on IF, and a pop never changes IOPL.
- R9: In virtual-8086 mode with `vme_i`=0 and IOPL<3, all five instructions (ops 0 to 4) fault and no flag changes.
- R10: In virtual-8086 mode with `vme_i`=1 and IOPL<3, the instructions take the virtual path. Clear-interrupt clears VIF. Set-interrupt sets VIF, but faults with no change when VIP=1. Push-flags places VIF in image bit 9. A pop copies image bit 9 into VIF and leaves IF and IOPL alone.
- R11: Flags change on the clock edge that samples `valid_i`=1, and `gp_fault_o` is high for exactly the following cycle. With `valid_i`=0 nothing changes and no fault is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Retire strobe for a flag instruction |
| op_i | input | 3 | 0 clear-int, 1 set-int, 2 push-flags, 3 pop-flags, 4 interrupt-return |
| cpl_i | input | 2 | Current privilege level |
| pe_i | input | 1 | Protection enable |
| vm_i | input | 1 | Virtual-8086 mode |
| vme_i | input | 1 | Virtual-8086 mode extensions enable |
| pvi_i | input | 1 | Protected-mode virtual interrupts enable |
| pop_img_i | input | 32 | Flags image read from the stack |
| if_o | output | 1 | Interrupt enable |
| vif_o | output | 1 | Virtual interrupt enable |
| vip_o | output | 1 | Virtual interrupt pending |
| iopl_o | output | 2 | I/O privilege level |
| push_img_o | output | 32 | Flags image to store |
| gp_fault_o | output | 1 | General-protection fault, error code 0, one-cycle pulse |

## Verification
All flag registers and the fault flag are one register away from the strobe. Their effect is therefore due in the cycle after the edge that samples `valid_i`. The push image is combinational from that registered state and the mode inputs, so it is valid in the same cycle. The driver puts each expected tuple into a queue before the sampling edge. The monitor pops it just after that edge and compares, which keeps every check aligned to exactly one register stage. Idle strobes are checked the same way, to confirm that state holds and no fault is raised.

// File: rtl/vif_pkg.sv
package vif_pkg;
  localparam int FLAG_W  = 32;
  localparam int RSV_B   = 1;
  localparam int IF_B    = 9;
  localparam int IOPL_LO = 12;
  localparam int VM_B    = 17;
  localparam int VIF_B   = 19;
  localparam int VIP_B   = 20;
  localparam int PL_W    = 2;
  localparam logic [PL_W-1:0] PL_MAX = '1;

  typedef enum logic [2:0] {
    OP_CLI   = 3'd0,
    OP_STI   = 3'd1,
    OP_PUSHF = 3'd2,
    OP_POPF  = 3'd3,
    OP_IRET  = 3'd4
  } op_e;

  typedef struct packed {
    logic            wr_if;
    logic            if_v;
    logic            wr_vif;
    logic            vif_v;
    logic            wr_iopl;
    logic [PL_W-1:0] iopl_v;
    logic            wr_vip;
    logic            vip_v;
    logic            fault;
  } upd_t;
endpackage

// File: rtl/vif_path_dec.sv
module vif_path_dec
  import vif_pkg::*;
(
  input  logic [2:0]        op_i,
  input  logic [PL_W-1:0]   cpl_i,
  input  logic              pe_i,
  input  logic              vm_i,
  input  logic              vme_i,
  input  logic              pvi_i,
  input  logic [PL_W-1:0]   iopl_i,
  input  logic              vip_i,
  input  logic [FLAG_W-1:0] img_i,
  output upd_t              upd_o,
  output logic              push_virt_o
);
  logic v86, prot, real_m, direct_ok, v86_virt, v86_flt, pvi_virt;
  logic [PL_W-1:0] eff_cpl;

  assign real_m    = !pe_i;
  assign v86       = pe_i && vm_i;
  assign prot      = pe_i && !vm_i;
  assign eff_cpl   = v86 ? PL_MAX : cpl_i;
  assign direct_ok = real_m || (eff_cpl <= iopl_i);
  assign v86_virt  = v86 && vme_i && (iopl_i != PL_MAX);
  assign v86_flt   = v86 && !vme_i && (iopl_i != PL_MAX);
  assign pvi_virt  = prot && pvi_i && (cpl_i == PL_MAX);
  assign push_virt_o = v86_virt;

  always_comb begin
    upd_o = '0;
    unique case (op_i)
      OP_CLI, OP_STI: begin
        if (direct_ok) begin
          upd_o.wr_if = 1'b1;
          upd_o.if_v  = (op_i == OP_STI);
        end else if (v86_virt || pvi_virt) begin
          if (op_i == OP_STI && vip_i) upd_o.fault = 1'b1;  // pending irq must reach the monitor
          else begin
            upd_o.wr_vif = 1'b1;
            upd_o.vif_v  = (op_i == OP_STI);
          end
        end else begin
          upd_o.fault = 1'b1;
        end
      end
      OP_PUSHF: upd_o.fault = v86_flt;
      OP_POPF, OP_IRET: begin
        if (v86_flt) upd_o.fault = 1'b1;
        else if (v86_virt) begin
          upd_o.wr_vif = 1'b1;
          upd_o.vif_v  = img_i[IF_B];
        end else begin
          upd_o.wr_if   = direct_ok;
          upd_o.if_v    = img_i[IF_B];
          upd_o.wr_iopl = real_m || (prot && cpl_i == '0);
          upd_o.iopl_v  = img_i[IOPL_LO +: PL_W];
          upd_o.wr_vif  = prot && cpl_i == '0;
          upd_o.vif_v   = img_i[VIF_B];
          upd_o.wr_vip  = prot && cpl_i == '0;
          upd_o.vip_v   = img_i[VIP_B];
        end
      end
      default: upd_o = '0;
    endcase
  end
endmodule

// File: rtl/vif_flag_regs.sv
module vif_flag_regs
  import vif_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            valid_i,
  input  upd_t            upd_i,
  output logic            if_o,
  output logic            vif_o,
  output logic            vip_o,
  output logic [PL_W-1:0] iopl_o,
  output logic            fault_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      if_o    <= 1'b0;
      vif_o   <= 1'b0;
      vip_o   <= 1'b0;
      iopl_o  <= '0;
      fault_o <= 1'b0;
    end else begin
      fault_o <= valid_i && upd_i.fault;
      if (valid_i && !upd_i.fault) begin
        if (upd_i.wr_if)   if_o   <= upd_i.if_v;
        if (upd_i.wr_vif)  vif_o  <= upd_i.vif_v;
        if (upd_i.wr_vip)  vip_o  <= upd_i.vip_v;
        if (upd_i.wr_iopl) iopl_o <= upd_i.iopl_v;
      end
    end
  end

  // R11
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> ($stable(if_o) && $stable(vif_o) && $stable(vip_o) && $stable(iopl_o) && !fault_o));
  // R9
  fault_no_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && upd_i.fault) |=> ($stable(if_o) && $stable(vif_o) && $stable(vip_o) && $stable(iopl_o)));
  // R11
  fault_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |=> (!fault_o || $past(valid_i)));
endmodule

// File: rtl/vif_ctrl.sv
module vif_ctrl
  import vif_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [2:0]        op_i,
  input  logic [1:0]        cpl_i,
  input  logic              pe_i,
  input  logic              vm_i,
  input  logic              vme_i,
  input  logic              pvi_i,
  input  logic [31:0]       pop_img_i,
  output logic              if_o,
  output logic              vif_o,
  output logic              vip_o,
  output logic [1:0]        iopl_o,
  output logic [31:0]       push_img_o,
  output logic              gp_fault_o
);
  upd_t upd;
  logic push_virt;

  vif_path_dec u_dec (
    .op_i(op_i), .cpl_i(cpl_i), .pe_i(pe_i), .vm_i(vm_i), .vme_i(vme_i),
    .pvi_i(pvi_i), .iopl_i(iopl_o), .vip_i(vip_o), .img_i(pop_img_i),
    .upd_o(upd), .push_virt_o(push_virt)
  );

  vif_flag_regs u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .upd_i(upd),
    .if_o(if_o), .vif_o(vif_o), .vip_o(vip_o), .iopl_o(iopl_o), .fault_o(gp_fault_o)
  );

  always_comb begin
    push_img_o = '0;
    push_img_o[RSV_B]              = 1'b1;
    push_img_o[IF_B]               = push_virt ? vif_o : if_o;
    push_img_o[IOPL_LO +: PL_W]    = iopl_o;
    push_img_o[VM_B]               = vm_i;
    push_img_o[VIF_B]              = vif_o;
    push_img_o[VIP_B]              = vip_o;
  end

  // R2
  real_sti_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == OP_STI && !pe_i) |=> (if_o && !gp_fault_o));
  // R2
  real_no_fault_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !pe_i) |=> !gp_fault_o);
  // R10
  vip_sti_fault_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == OP_STI && pe_i && vm_i && vme_i && iopl_o != 2'd3 && vip_o)
      |=> (gp_fault_o && $stable(vif_o)));
endmodule

// File: tb/vif_ctrl_tb_top.sv
module vif_ctrl_tb_top;
  logic clk = 0, rst_n = 0, valid = 0, pe = 0, vm = 0, vme = 0, pvi = 0;
  logic [2:0] op = 0;
  logic [1:0] cpl = 0;
  logic [31:0] img = 0;
  logic if_w, vif_w, vip_w, flt_w;
  logic [1:0] iopl_w;
  logic [31:0] push_w;
  int errors = 0, checks = 0;

  always #5 clk = ~clk;

  vif_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .op_i(op), .cpl_i(cpl),
    .pe_i(pe), .vm_i(vm), .vme_i(vme), .pvi_i(pvi), .pop_img_i(img),
    .if_o(if_w), .vif_o(vif_w), .vip_o(vip_w), .iopl_o(iopl_w),
    .push_img_o(push_w), .gp_fault_o(flt_w)
  );

  typedef struct packed {
    logic f_if, f_vif, f_vip; logic [1:0] iopl; logic flt; logic [31:0] pimg;
  } exp_t;
  exp_t  q[$];
  string tq[$];
  logic m_if = 0, m_vif = 0, m_vip = 0;
  logic [1:0] m_iopl = 0;

  function automatic logic [31:0] mk_img(logic i, logic vi, logic vp, logic [1:0] pl, logic v);
    logic [31:0] r = 32'h2;
    r[9] = i; r[13:12] = pl; r[17] = v; r[19] = vi; r[20] = vp;
    return r;
  endfunction

  task automatic cmp(string tag, exp_t e);
    exp_t a = '{if_w, vif_w, vip_w, iopl_w, flt_w, push_w};
    checks++;
    if (a !== e) begin
      errors++;
      $display("FAIL %s: got if=%b vif=%b vip=%b iopl=%0d flt=%b img=%h exp if=%b vif=%b vip=%b iopl=%0d flt=%b img=%h",
        tag, a.f_if, a.f_vif, a.f_vip, a.iopl, a.flt, a.pimg,
        e.f_if, e.f_vif, e.f_vip, e.iopl, e.flt, e.pimg);
    end
  endtask

  always @(posedge clk) if (q.size() > 0) begin
    #2;
    cmp(tq.pop_front(), q.pop_front());
  end

  task automatic step(string tag, bit vld, logic [2:0] o, bit p, bit v, bit ve, bit pv,
                      logic [1:0] c, logic [31:0] im);
    logic ni = m_if, nv = m_vif, np = m_vip, f = 0;
    logic [1:0] nl = m_iopl;
    bit cs = (o <= 1), st = (o == 1), pp = (o == 3 || o == 4);
    @(negedge clk);
    valid = vld; op = o; pe = p; vm = v; vme = ve; pvi = pv; cpl = c; img = im;
    if (vld) begin
      if (!p) begin
        if (cs) ni = st;
        else if (pp) begin ni = im[9]; nl = im[13:12]; end
      end else if (v) begin
        if (m_iopl == 3) begin
          if (cs) ni = st; else if (pp) ni = im[9];
        end else if (!ve) begin
          f = (o <= 4);
        end else begin
          if (o == 0) nv = 0;
          else if (st) begin if (m_vip) f = 1; else nv = 1; end
          else if (pp) nv = im[9];
        end
      end else begin
        if (c <= m_iopl) begin
          if (cs) ni = st;
          else if (pp) begin
            ni = im[9];
            if (c == 0) begin nl = im[13:12]; nv = im[19]; np = im[20]; end
          end
        end else if (cs) begin
          if (pv && c == 3) begin if (st && m_vip) f = 1; else nv = st; end
          else f = 1;
        end
      end
    end
    m_if = ni; m_vif = nv; m_vip = np; m_iopl = nl;
    tq.push_back(tag);
    q.push_back('{ni, nv, np, nl, f,
      mk_img((p && v && ve && nl != 3) ? nv : ni, nv, np, nl, v)});
  endtask

  initial begin
    #(200000 * 10);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #12;
    cmp("R1 reset", '{0, 0, 0, 2'd0, 0, mk_img(0, 0, 0, 0, 0)});
    @(negedge clk); rst_n = 1;
    cmp("R1 after release", '{0, 0, 0, 2'd0, 0, mk_img(0, 0, 0, 0, 0)});
    step("R2 real sti",      1, 1, 0, 0, 0, 0, 0, 0);
    step("R2 real cli",      1, 0, 0, 0, 0, 0, 0, 0);
    step("R4 real popf",     1, 3, 0, 0, 0, 0, 0, 32'h0018_2202);
    step("R3 real pushf",    1, 2, 0, 0, 0, 0, 0, 0);
    step("R2 real sti iopl", 1, 1, 0, 0, 0, 0, 3, 0);
    step("R4 real iret",     1, 4, 0, 0, 0, 0, 0, 32'h0000_0002);
    step("R5 prot cpl0 pop", 1, 3, 1, 0, 0, 0, 0, 32'h0018_1202);
    step("R6 prot cpl1 cli", 1, 0, 1, 0, 0, 0, 1, 0);
    step("R6 prot cpl1 sti", 1, 1, 1, 0, 0, 0, 1, 0);
    step("R7 prot cpl2 sti", 1, 1, 1, 0, 0, 0, 2, 0);
    step("R7 pvi sti vip",   1, 1, 1, 0, 0, 1, 3, 0);
    step("R7 pvi cli",       1, 0, 1, 0, 0, 1, 3, 0);
    step("R7 cpl3 popf",     1, 3, 1, 0, 0, 0, 3, 32'h0000_0002);
    step("R5 prot cpl0 clr", 1, 4, 1, 0, 0, 0, 0, 32'h0000_0002);
    step("R7 pvi sti",       1, 1, 1, 0, 0, 1, 3, 0);
    step("R9 v86 sti",       1, 1, 1, 1, 0, 0, 3, 0);
    step("R9 v86 pushf",     1, 2, 1, 1, 0, 0, 3, 0);
    step("R9 v86 iret",      1, 4, 1, 1, 0, 0, 3, 32'h0000_0202);
    step("R9 v86 cli",       1, 0, 1, 1, 0, 0, 3, 0);
    step("R10 v86 cli",      1, 0, 1, 1, 1, 0, 3, 0);
    step("R10 v86 sti",      1, 1, 1, 1, 1, 0, 3, 0);
    step("R10 v86 pushf",    1, 2, 1, 1, 1, 0, 3, 0);
    step("R10 v86 popf",     1, 3, 1, 1, 1, 0, 3, 32'h0000_3002);
    step("R5 set vip",       1, 3, 1, 0, 0, 0, 0, 32'h0010_0202);
    step("R10 v86 sti vip",  1, 1, 1, 1, 1, 0, 3, 0);
    step("R11 idle",         0, 1, 1, 1, 1, 0, 3, 0);
    step("R5 iopl3",         1, 3, 1, 0, 0, 0, 0, 32'h0000_3002);
    step("R8 v86 sti",       1, 1, 1, 1, 1, 0, 3, 0);
    step("R8 v86 pushf",     1, 2, 1, 1, 1, 0, 3, 0);
    step("R8 v86 popf",      1, 3, 1, 1, 0, 0, 3, 32'h0000_0002);
    step("R11 idle cli",     0, 0, 0, 0, 0, 0, 0, 0);
    @(negedge clk); valid = 0;
    repeat (3) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule